// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog for a bus-attached subsystem. Software reaches it through a word-addressed write port and a read mux. The count starts and the count clock is chosen only through configuration writes. Two paired magic words written to the count register guard the block. One pair restarts the count; the other pair opens a short window in which configuration writes are accepted. Any malformed key traffic is treated as a fault.

The count advances on one of four tick sources. These are the bus clock itself or three tick enables that arrive from outside clock generators. The three external ticks are registered once in the bus domain. When the count meets the programmed timeout, the block latches a sticky expiry flag and emits a one-cycle reset request. It emits the same request on a key-sequence fault or on a refresh that arrives too early while windowed refresh is active.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (run bit 7 clear, permit bit 5 set, flag and source clear), the count reads 0, the timeout reads 0x1000, the window reads 0 and `rst_req` is low.
- R2: Word index 0 holds control byte A in lane 0 and control byte B in lane 1. Index 1 is the count, index 2 the 16-bit timeout and index 3 the 16-bit window. Each byte lane is written only when its enable is set.
- R3: Writes to the run bit, the permit bit, the source field, the timeout and the window take effect only during the 256 bus cycles that follow an unlock. An unlock is the full-word value 0xC520 and then 0xD928 written to the count register. Outside that span such writes leave the registers unchanged.
- R4: A refresh is the full-word value 0xA602 and then 0xB480 written to the count register. It clears the count to 0.
- R5: With run bit 7 set, the count increments once per selected tick. Source field bits 9:8 select the tick: 0 every bus cycle, 1 `tick_lpo`, 2 `tick_32k`, 3 `tick_ext`. External ticks act one cycle after they are sampled. With the run bit clear the count holds.
- R6: When the count equals the timeout while running, the count returns to 0, the expiry flag (word bit 14) sets and `rst_req` pulses.
- R7: Writing 1 to word bit 14 with lane 1 enabled clears the expiry flag, whether or not the block is unlocked.
- R8: A full-word count-register write that is not a first key word raises `rst_req`. So does a second word that does not match its first word. So does any other write that lands between a first key word and its second word.
- R9: With a nonzero window, a refresh while the count is below the window raises `rst_req` and does not clear the count. A refresh at or above the window clears it normally.
- R10: Once the permit bit has been written 0, later unlock sequences open no configuration span and raise no fault.
- R11: Each expiry or fault produces exactly one cycle of `rst_req`. The count register reads back the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 2 | Word index of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables |
| rd_word | input | 2 | Word index for the read mux |
| rd_data | output | 32 | Read data for `rd_word` |
| tick_lpo | input | 1 | Low-power 1 kHz tick enable |
| tick_32k | input | 1 | 32 kHz tick enable |
| tick_ext | input | 1 | External tick enable |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Suppose the key-pair tracker is left holding a half-received pair. Then the next unrelated register write shows up as an unexpected `rst_req` in the cycle right after that write. Suppose the configuration span counter runs too long or ignores the permit bit. Then a timeout write that should be dropped reads back changed on the very next read. A wrong count or compare state shows up as a count value off by some ticks, or as an expiry pulse that arrives early, late or twice. The bench catches these by reading the count after a known number of ticks and by tallying pulses after each step.

// File: rtl/kwdt_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 32-bit write bus; key words are compared on the full word.
package kwdt_pkg;
    localparam logic [31:0] KEY_REFRESH_A = 32'h0000_A602;
    localparam logic [31:0] KEY_REFRESH_B = 32'h0000_B480;
    localparam logic [31:0] KEY_UNLOCK_A  = 32'h0000_C520;
    localparam logic [31:0] KEY_UNLOCK_B  = 32'h0000_D928;

    localparam int CTLA_RUN_BIT    = 7;
    localparam int CTLA_PERMIT_BIT = 5;
    localparam int CTLB_FLAG_BIT   = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_REF_HALF = 2'd1,
        SEQ_UNL_HALF = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_BUS  = 2'd0,
        SRC_LPO  = 2'd1,
        SRC_32K  = 2'd2,
        SRC_EXT  = 2'd3
    } tick_src_t;

    localparam logic [1:0] WORD_CTRL    = 2'd0;
    localparam logic [1:0] WORD_COUNT   = 2'd1;
    localparam logic [1:0] WORD_TIMEOUT = 2'd2;
    localparam logic [1:0] WORD_WINDOW  = 2'd3;
endpackage

// File: rtl/kwdt_keyseq.sv
// Tracks the two-word key pairs written to the count register.
// Produces a one-cycle refresh or unlock strobe on a completed pair,
// and a fault strobe on any malformed or interrupted pair.
// Assumes count_wr and other_wr are never high together.
module kwdt_keyseq
    import kwdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_wr,
    input  logic          other_wr,
    input  logic [DW-1:0] wdata,
    output logic          refresh_ok,
    output logic          unlock_ok,
    output logic          seq_fault
);
    seq_state_t state_q, state_d;

    // Next-state and strobe decode for the key-pair tracker.
    always_comb begin
        state_d    = state_q;
        refresh_ok = 1'b0;
        unlock_ok  = 1'b0;
        seq_fault  = 1'b0;
        if (count_wr) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (wdata == DW'(KEY_REFRESH_A))     state_d = SEQ_REF_HALF;
                    else if (wdata == DW'(KEY_UNLOCK_A)) state_d = SEQ_UNL_HALF;
                    else                                 seq_fault = 1'b1;
                end
                SEQ_REF_HALF: begin
                    state_d = SEQ_IDLE;
                    if (wdata == DW'(KEY_REFRESH_B)) refresh_ok = 1'b1;
                    else                             seq_fault  = 1'b1;
                end
                SEQ_UNL_HALF: begin
                    state_d = SEQ_IDLE;
                    if (wdata == DW'(KEY_UNLOCK_B)) unlock_ok = 1'b1;
                    else                            seq_fault = 1'b1;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end else if (other_wr && state_q != SEQ_IDLE) begin
            state_d   = SEQ_IDLE;
            seq_fault = 1'b1;
        end
    end

    // State register for the tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // R8: a half-received pair is always resolved by the very next write.
    assert_pair_resolved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE && (count_wr || other_wr)) |=> state_q == SEQ_IDLE)
        else $error("pending key half survived a write");

    // R4: a half-pair state is entered only from a count-register write.
    assert_half_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !count_wr) |=> state_q == SEQ_IDLE)
        else $error("key tracker left idle without a count write");
endmodule

// File: rtl/kwdt_cfg_gate.sv
// Opens a configuration span of OPEN_CYCLES bus cycles after an unlock,
// but only while the permit bit allows it.
module kwdt_cfg_gate #(
    parameter int OPEN_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_ok,
    input  logic permit,
    output logic cfg_open
);
    localparam int CW = $clog2(OPEN_CYCLES + 1);

    logic [CW-1:0] left_q;

    // Load on a permitted unlock, then count the span down to closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left_q <= '0;
        else if (unlock_ok && permit) left_q <= CW'(OPEN_CYCLES);
        else if (left_q != '0)       left_q <= left_q - 1'b1;
    end

    assign cfg_open = (left_q != '0);

    // R3: a permitted unlock always opens the span on the next cycle.
    assert_gate_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_ok && permit) |=> cfg_open)
        else $error("unlock did not open configuration span");

    // R10: without a permitted unlock a closed span stays closed.
    assert_gate_stays_shut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && !(unlock_ok && permit)) |=> !cfg_open)
        else $error("configuration span opened without permission");
endmodule

// File: rtl/kwdt_counter.sv
// Up-counter with timeout compare and early-refresh window check.
// Assumes tick is already in the bus clock domain.
module kwdt_counter #(
    parameter int CW = 32,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic          refresh_ok,
    input  logic [TW-1:0] limit,
    input  logic [TW-1:0] window,
    output logic [CW-1:0] count,
    output logic          expire,
    output logic          win_fault
);
    assign expire    = enable && (count == CW'(limit));
    assign win_fault = refresh_ok && (window != '0) && (count < CW'(window));

    // Clear on expiry or accepted refresh, else advance on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  count <= '0;
        else if (expire || (refresh_ok && !win_fault)) count <= '0;
        else if (enable && tick)                     count <= count + 1'b1;
    end

    // R6: an expiry always restarts the count.
    assert_expire_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == '0)
        else $error("count not cleared after expiry");

    // R5: a stopped counter holds its value unless refreshed.
    assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !refresh_ok) |=> $stable(count))
        else $error("stopped counter moved");

    // R9: an early refresh on a stopped counter leaves the count alone.
    assert_early_refresh_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_fault && !enable) |=> $stable(count))
        else $error("early refresh changed the count");
endmodule

// File: rtl/kwdt_top.sv
// Keyed-sequence watchdog: register decode, tick selection, reset request.
// Assumes DW is a multiple of 8, DW >= 16 and TW <= DW.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          TW          = 16,
    parameter int          OPEN_CYCLES = 256,
    parameter logic [15:0] TOUT_INIT   = 16'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_word,
    input  logic [DW-1:0] wr_data,
    input  logic [DW/8-1:0] wr_be,
    input  logic [1:0]    rd_word,
    output logic [DW-1:0] rd_data,
    input  logic          tick_lpo,
    input  logic          tick_32k,
    input  logic          tick_ext,
    output logic          rst_req
);
    localparam int TLANES = TW / 8;

    logic          run_q, permit_q, flag_q;
    tick_src_t     src_q;
    logic [TW-1:0] limit_q, window_q;
    logic [2:0]    tick_q;
    logic          count_wr, other_wr, refresh_ok, unlock_ok, seq_fault;
    logic          cfg_open, expire, win_fault, tick_sel;
    logic [DW-1:0] count;
    logic [7:0]    ctl_a, ctl_b;

    assign count_wr = wr_en && (wr_word == WORD_COUNT) && (&wr_be);
    assign other_wr = wr_en && !count_wr;

    kwdt_keyseq #(.DW(DW)) u_keyseq (
        .clk(clk), .rst_n(rst_n), .count_wr(count_wr), .other_wr(other_wr),
        .wdata(wr_data), .refresh_ok(refresh_ok), .unlock_ok(unlock_ok),
        .seq_fault(seq_fault)
    );

    kwdt_cfg_gate #(.OPEN_CYCLES(OPEN_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .unlock_ok(unlock_ok), .permit(permit_q),
        .cfg_open(cfg_open)
    );

    kwdt_counter #(.CW(DW), .TW(TW)) u_counter (
        .clk(clk), .rst_n(rst_n), .enable(run_q), .tick(tick_sel),
        .refresh_ok(refresh_ok), .limit(limit_q), .window(window_q),
        .count(count), .expire(expire), .win_fault(win_fault)
    );

    // Register the external tick enables into the bus domain.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= {tick_ext, tick_32k, tick_lpo};
    end

    // Pick the tick that drives the counter.
    always_comb begin
        unique case (src_q)
            SRC_BUS: tick_sel = 1'b1;
            SRC_LPO: tick_sel = tick_q[0];
            SRC_32K: tick_sel = tick_q[1];
            SRC_EXT: tick_sel = tick_q[2];
            default: tick_sel = 1'b0;
        endcase
    end

    // Control bytes: gated configuration bits plus the sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            permit_q <= 1'b1;
            src_q    <= SRC_BUS;
            flag_q   <= 1'b0;
        end else begin
            if (wr_en && wr_word == WORD_CTRL && wr_be[0] && cfg_open) begin
                run_q    <= wr_data[CTLA_RUN_BIT];
                permit_q <= wr_data[CTLA_PERMIT_BIT];
            end
            if (wr_en && wr_word == WORD_CTRL && wr_be[1] && cfg_open)
                src_q <= tick_src_t'(wr_data[9:8]);
            if (expire)
                flag_q <= 1'b1;
            else if (wr_en && wr_word == WORD_CTRL && wr_be[1] && wr_data[8 + CTLB_FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    // Timeout and window registers, written lane by lane while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q  <= TW'(TOUT_INIT);
            window_q <= '0;
        end else if (wr_en && cfg_open) begin
            for (int b = 0; b < TLANES; b++) begin
                if (wr_word == WORD_TIMEOUT && wr_be[b]) limit_q[b*8 +: 8]  <= wr_data[b*8 +: 8];
                if (wr_word == WORD_WINDOW  && wr_be[b]) window_q[b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // One-cycle reset request on any expiry or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire || seq_fault || win_fault;
    end

    assign ctl_a = {run_q, 1'b0, permit_q, 5'b0};
    assign ctl_b = {1'b0, flag_q, 4'b0, src_q};

    // Read mux over the four word slots.
    always_comb begin
        unique case (rd_word)
            WORD_CTRL:    rd_data = DW'({ctl_b, ctl_a});
            WORD_COUNT:   rd_data = count;
            WORD_TIMEOUT: rd_data = DW'(limit_q);
            default:      rd_data = DW'(window_q);
        endcase
    end

    // R3: a timeout write outside the configuration span changes nothing.
    assert_locked_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word == WORD_TIMEOUT && !cfg_open) |=> $stable(limit_q))
        else $error("timeout changed while locked");

    // R6: an expiry sets the flag and requests reset on the next cycle.
    assert_expiry_reports_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (flag_q && rst_req))
        else $error("expiry not reported");

    // R8: a key fault is followed by a reset request.
    assert_fault_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fault |=> rst_req)
        else $error("key fault without reset request");
endmodule

// File: tb/kwdt_top_test.sv
// Scoreboard bench: driver tasks queue expected values, a negedge monitor
// pops them and compares against rd_data or the tally of rst_req cycles.
module kwdt_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_word;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [1:0]  rd_word;
    logic [31:0] rd_data;
    logic        tick_lpo, tick_32k, tick_ext;
    logic        rst_req;

    always #4 clk = ~clk;

    kwdt_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_data(wr_data), .wr_be(wr_be), .rd_word(rd_word), .rd_data(rd_data),
        .tick_lpo(tick_lpo), .tick_32k(tick_32k), .tick_ext(tick_ext),
        .rst_req(rst_req)
    );

    typedef struct {
        string       tag;
        bit          is_pulse;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    bit    done   = 1'b0;

    // Monitor: tally reset-request cycles, then settle one queued item.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        if (rst_n && rst_req) pulses++;
        if (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            act = it.is_pulse ? 32'(pulses) : rd_data;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic bus_wr(input logic [1:0] w, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_word = w; wr_data = d; wr_be = be;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic expect_rd(input string tag, input logic [1:0] w, input logic [31:0] e);
        item_t it;
        rd_word = w;
        it.tag = tag; it.is_pulse = 1'b0; it.exp = e;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_pulses(input string tag, input int e);
        item_t it;
        it.tag = tag; it.is_pulse = 1'b1; it.exp = 32'(e);
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic do_unlock();
        bus_wr(2'd1, 32'h0000_C520, 4'hF);
        bus_wr(2'd1, 32'h0000_D928, 4'hF);
    endtask

    task automatic do_refresh();
        bus_wr(2'd1, 32'h0000_A602, 4'hF);
        bus_wr(2'd1, 32'h0000_B480, 4'hF);
    endtask

    task automatic ext_ticks(input int n);
        @(posedge clk); #1 tick_ext = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_ext = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_word = 2'd0; wr_data = '0; wr_be = '0;
        rd_word = 2'd0; tick_lpo = 1'b0; tick_32k = 1'b0; tick_ext = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd("R1 control word", 2'd0, 32'h0000_0020);
        expect_rd("R1 count", 2'd1, 32'h0);
        expect_rd("R1 timeout", 2'd2, 32'h0000_1000);
        expect_rd("R1 window", 2'd3, 32'h0);
        expect_pulses("R1 no request", 0);

        // R3 locked timeout write is dropped
        bus_wr(2'd2, 32'h0000_0055, 4'hF);
        expect_rd("R3 locked timeout", 2'd2, 32'h0000_1000);

        // R2 unlocked configuration: timeout 40, external tick, run + permit
        do_unlock();
        bus_wr(2'd2, 32'h0000_0028, 4'hF);
        bus_wr(2'd0, 32'h0000_03A0, 4'b0011);
        expect_rd("R2 timeout readback", 2'd2, 32'h0000_0028);
        expect_rd("R2 control readback", 2'd0, 32'h0000_03A0);
        expect_pulses("R4 unlock is not a fault", 0);

        // R5 external ticks: five ticks, five counts
        ext_ticks(5);
        expect_rd("R5 count after ticks", 2'd1, 32'd5);

        // R4 refresh clears count
        do_refresh();
        expect_rd("R4 count cleared", 2'd1, 32'd0);
        expect_pulses("R4 refresh no fault", 0);

        // R8 stray value to count register
        bus_wr(2'd1, 32'h0000_1234, 4'hF);
        expect_pulses("R8 stray value", 1);

        // R8 first half then a write elsewhere
        bus_wr(2'd1, 32'h0000_A602, 4'hF);
        bus_wr(2'd2, 32'h0000_0028, 4'hF);
        expect_pulses("R8 interrupted pair", 2);

        // R6 expiry on bus clock with timeout 40
        do_unlock();
        bus_wr(2'd0, 32'h0000_00A0, 4'b0011);
        repeat (50) @(posedge clk);
        #1;
        expect_rd("R6 flag set", 2'd0, 32'h0000_40A0);
        expect_pulses("R11 single cycle per expiry", 3);
        do_unlock();
        bus_wr(2'd0, 32'h0000_0020, 4'b0001);
        expect_rd("R2 lane 0 only", 2'd0, 32'h0000_4020);
        expect_pulses("R6 one expiry only", 3);

        // R7 flag clear by writing one
        bus_wr(2'd0, 32'h0000_4000, 4'b0010);
        expect_rd("R7 flag cleared", 2'd0, 32'h0000_0020);
        do_refresh();
        expect_rd("R4 refresh while stopped", 2'd1, 32'd0);

        // R9 windowed refresh
        do_unlock();
        bus_wr(2'd2, 32'h0000_03E8, 4'hF);
        bus_wr(2'd3, 32'h0000_000A, 4'hF);
        bus_wr(2'd0, 32'h0000_03A0, 4'b0011);
        do_refresh();
        expect_pulses("R9 early refresh", 4);
        ext_ticks(12);
        expect_rd("R11 live count", 2'd1, 32'd12);
        do_refresh();
        expect_rd("R9 late refresh clears", 2'd1, 32'd0);
        expect_pulses("R9 late refresh no fault", 4);

        // R3 configuration span closes after 256 cycles
        do_unlock();
        repeat (300) @(posedge clk);
        bus_wr(2'd2, 32'h0000_022B, 4'hF);
        expect_rd("R3 span expired", 2'd2, 32'h0000_03E8);

        // R10 permit cleared: later unlock ignored without fault
        do_unlock();
        bus_wr(2'd0, 32'h0000_0080, 4'b0001);
        expect_rd("R10 permit cleared", 2'd0, 32'h0000_0380);
        repeat (300) @(posedge clk);
        do_unlock();
        expect_pulses("R10 ignored unlock no fault", 4);
        bus_wr(2'd2, 32'h0000_004D, 4'hF);
        expect_rd("R10 still locked", 2'd2, 32'h0000_03E8);

        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule